// File: doc/BRIEF.md
# Legacy Memory Routing Decoder

This block decides, for every processor memory cycle that falls inside the first megabyte of the address space, whether the cycle is claimed by main DRAM or passed on to the PCI/AGP side of the host bridge. The lowest 512 KB always belongs to DRAM. The next 128 KB can be turned into a hole that is forwarded to PCI. The 128 KB video window is normally forwarded, but it can be opened to DRAM for system-management cycles. The top 256 KB is cut into thirteen shadow segments. Each segment has its own read-steering bit and its own write-steering bit.

Configuration arrives as level inputs driven by the register file of the bridge. The decoder samples them in the same cycle as the request. A request is presented with a valid strobe, and the decision comes out of a register one clock later together with its own valid flag. Only addresses below 1 MB are handled here.

Top module: `lrd_top`

## Requirements
- R1: Any request with an address in 0x00000–0x7FFFF is routed to DRAM, whatever the configuration.
- R2: A request in 0x80000–0x9FFFF is routed to DRAM when `cfg_dos_hole` is 0 and to PCI when it is 1.
- R3: A request in 0xA0000–0xBFFFF with `req_smm` low is routed to PCI, regardless of the shadow bits and of `cfg_smram_en`.
- R4: A request in 0xA0000–0xBFFFF with `req_smm` high is routed to DRAM when `cfg_smram_en` is 1 and to PCI when it is 0.
- R5: 0xC0000–0xDFFFF consists of eight 16 KB segments controlled by bits 0..7 of the steering vectors. The bit index is (address − 0xC0000) / 0x4000.
- R6: 0xE0000–0xEFFFF consists of four 16 KB segments controlled by bits 8..11. The bit index is 8 + (address − 0xE0000) / 0x4000.
- R7: 0xF0000–0xFFFFF is one 64 KB segment controlled by bit 12.
- R8: In a shadow segment, a read (`req_write`=0) goes to DRAM only if the segment's `cfg_rd_en` bit is 1. A write goes to DRAM only if its `cfg_wr_en` bit is 1. In every other case the cycle goes to PCI.
- R9: `rsp_valid` equals `req_valid` delayed by one clock, and `rsp_to_dram` carries that request's decision (1 = DRAM, 0 = PCI). `rsp_to_dram` is 0 whenever `rsp_valid` is 0.
- R10: While `rst_n` is low at a clock edge, both `rsp_valid` and `rsp_to_dram` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 20 | Cycle address below 1 MB |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_smm | input | 1 | Cycle issued in system-management mode |
| cfg_rd_en | input | 13 | Per-segment read steering to DRAM |
| cfg_wr_en | input | 13 | Per-segment write steering to DRAM |
| cfg_dos_hole | input | 1 | Turns 0x80000–0x9FFFF into a PCI hole |
| cfg_smram_en | input | 1 | Opens the video window to DRAM for SMM cycles |
| rsp_valid | output | 1 | Decision valid, one clock after the request |
| rsp_to_dram | output | 1 | 1 = DRAM, 0 = PCI |

## Verification
The bench hits the first and last byte of every region and every segment. For each segment in turn it enables that segment alone, once for each read/write steering combination, and it repeats the sweep for every setting of the hole and SMRAM controls, in both SMM and normal mode. An off-by-one in the segment index would steer an edge address by a neighbour's bit, and with only one segment enabled that mistake routes the wrong way. If the read and write vectors were swapped, a segment enabled for writes only would claim reads. A video window that ignored `req_smm` would hand normal cycles to DRAM whenever SMRAM is enabled, and a missing hole would keep 0x9FFFF in DRAM. Idle gaps between bursts expose a valid flag that sticks high or a target flag left asserted.

// File: rtl/lrd_pkg.sv
`timescale 1ns/1ps
// Shared types for the legacy memory routing decoder.
// Assumes the decoded space is exactly the first megabyte.
package lrd_pkg;
    // Coarse region classes of the first megabyte
    typedef enum logic [1:0] {
        RGN_BASE   = 2'd0,  // fixed DRAM
        RGN_HOLE   = 2'd1,  // switchable hole
        RGN_VIDEO  = 2'd2,  // legacy video / SMM window
        RGN_SHADOW = 2'd3   // attribute-steered segments
    } region_e;
endpackage

// File: rtl/lrd_region_decode.sv
`timescale 1ns/1ps
// Classifies an address into a region class and, for the shadow area,
// a segment index. Assumes the top two address bits select 256 KB quarters
// and the shadow area is made of GRAN-sized granules, with every granule
// from index SEG_CNT-1 upward folded into the last (large) segment.
module lrd_region_decode #(
    parameter int ADDR_W  = 20,
    parameter int GRAN_W  = 14,
    parameter int SEG_CNT = 13,
    parameter int IDX_W   = $clog2(SEG_CNT)
) (
    input  logic [ADDR_W-1:0]  addr,
    output lrd_pkg::region_e   region,
    output logic [IDX_W-1:0]   seg_idx
);
    localparam int GW = ADDR_W - 2 - GRAN_W;

    logic [GW-1:0] gran;
    assign gran = addr[ADDR_W-3:GRAN_W];

    // Pick the region class from the upper address bits
    always_comb begin
        unique case (addr[ADDR_W-1 -: 2])
            2'b00, 2'b01: region = lrd_pkg::RGN_BASE;
            2'b10:        region = addr[ADDR_W-3] ? lrd_pkg::RGN_VIDEO
                                                  : lrd_pkg::RGN_HOLE;
            default:      region = lrd_pkg::RGN_SHADOW;
        endcase
    end

    // Map the granule number to a segment index, folding the top granules
    always_comb begin
        if (gran >= GW'(SEG_CNT - 1))
            seg_idx = IDX_W'(SEG_CNT - 1);
        else
            seg_idx = IDX_W'(gran);
    end
endmodule

// File: rtl/lrd_attr_pick.sv
`timescale 1ns/1ps
// Selects the steering bit of one shadow segment for the current cycle
// direction. Assumes seg_idx is below SEG_CNT.
module lrd_attr_pick #(
    parameter int SEG_CNT = 13,
    parameter int IDX_W   = $clog2(SEG_CNT)
) (
    input  logic [IDX_W-1:0]   seg_idx,
    input  logic               is_write,
    input  logic [SEG_CNT-1:0] rd_en,
    input  logic [SEG_CNT-1:0] wr_en,
    output logic               to_dram
);
    logic [SEG_CNT-1:0] sel;
    logic [SEG_CNT-1:0] dir_en;

    // One-hot segment select, one comparator per segment
    for (genvar g = 0; g < SEG_CNT; g++) begin : g_sel
        assign sel[g] = (seg_idx == IDX_W'(g));
    end

    // Choose the steering vector that matches the cycle direction
    assign dir_en  = is_write ? wr_en : rd_en;
    // Reduce the selected bit
    assign to_dram = |(sel & dir_en);
endmodule

// File: rtl/lrd_route_reg.sv
`timescale 1ns/1ps
// Output stage holding the routing decision for one clock.
// Assumes the decision is meaningful only while in_valid is high.
module lrd_route_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_dram,
    output logic out_valid,
    output logic out_dram
);
    // Register the decision; the target flag is forced low when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_dram  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_dram  <= in_valid & in_dram;
        end
    end
endmodule

// File: rtl/lrd_top.sv
`timescale 1ns/1ps
// Routing decoder for cycles below 1 MB: fixed DRAM base, switchable hole,
// video window with an SMM override, and per-segment read/write steering.
// Assumes configuration inputs are stable while a request is presented.
module lrd_top #(
    parameter int ADDR_W  = 20,
    parameter int GRAN_W  = 14,
    parameter int SEG_CNT = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    input  logic               req_smm,
    input  logic [SEG_CNT-1:0] cfg_rd_en,
    input  logic [SEG_CNT-1:0] cfg_wr_en,
    input  logic               cfg_dos_hole,
    input  logic               cfg_smram_en,
    output logic               rsp_valid,
    output logic               rsp_to_dram
);
    localparam int IDX_W = $clog2(SEG_CNT);

    lrd_pkg::region_e region;
    logic [IDX_W-1:0] seg_idx;
    logic             shadow_dram;
    logic             route_dram;

    lrd_region_decode #(
        .ADDR_W (ADDR_W),
        .GRAN_W (GRAN_W),
        .SEG_CNT(SEG_CNT),
        .IDX_W  (IDX_W)
    ) u_decode (
        .addr   (req_addr),
        .region (region),
        .seg_idx(seg_idx)
    );

    lrd_attr_pick #(
        .SEG_CNT(SEG_CNT),
        .IDX_W  (IDX_W)
    ) u_pick (
        .seg_idx (seg_idx),
        .is_write(req_write),
        .rd_en   (cfg_rd_en),
        .wr_en   (cfg_wr_en),
        .to_dram (shadow_dram)
    );

    // Combine the region class with its controls into one decision
    always_comb begin
        unique case (region)
            lrd_pkg::RGN_BASE:  route_dram = 1'b1;
            lrd_pkg::RGN_HOLE:  route_dram = ~cfg_dos_hole;
            lrd_pkg::RGN_VIDEO: route_dram = req_smm & cfg_smram_en;
            default:            route_dram = shadow_dram;
        endcase
    end

    lrd_route_reg u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_dram  (route_dram),
        .out_valid(rsp_valid),
        .out_dram (rsp_to_dram)
    );
endmodule

// File: rtl/lrd_checker.sv
`timescale 1ns/1ps
// Property checker for lrd_top, relating request ports to response ports.
// Assumes the default 20-bit, 13-segment layout of the first megabyte.
module lrd_checker #(
    parameter int ADDR_W  = 20,
    parameter int SEG_CNT = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               req_write,
    input logic               req_smm,
    input logic [SEG_CNT-1:0] cfg_rd_en,
    input logic [SEG_CNT-1:0] cfg_wr_en,
    input logic               cfg_dos_hole,
    input logic               cfg_smram_en,
    input logic               rsp_valid,
    input logic               rsp_to_dram
);
    localparam int TOP = SEG_CNT - 1;

    assert_base_dram_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[ADDR_W-1]) |=> rsp_to_dram);

    assert_hole_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1 -: 3] == 3'b100)
        |=> (rsp_to_dram == !$past(cfg_dos_hole)));

    assert_video_pci_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_smm && req_addr[ADDR_W-1 -: 3] == 3'b101)
        |=> !rsp_to_dram);

    assert_video_smm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_smm && req_addr[ADDR_W-1 -: 3] == 3'b101)
        |=> (rsp_to_dram == $past(cfg_smram_en)));

    assert_top_segment_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1 -: 4] == 4'hF)
        |=> (rsp_to_dram == ($past(req_write) ? $past(cfg_wr_en[TOP])
                                              : $past(cfg_rd_en[TOP]))));

    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_idle_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_to_dram);

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !rsp_to_dram));
endmodule

bind lrd_top lrd_checker #(.ADDR_W(ADDR_W), .SEG_CNT(SEG_CNT)) u_chk (.*);

// File: tb/lrd_top_tb.sv
`timescale 1ns/1ps
module lrd_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_smm = 1'b0;
    logic [12:0] cfg_rd_en = '0;
    logic [12:0] cfg_wr_en = '0;
    logic        cfg_dos_hole = 1'b0;
    logic        cfg_smram_en = 1'b0;
    logic        rsp_valid;
    logic        rsp_to_dram;

    int checks = 0;
    int failures = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    bit          q_exp[$];
    string       q_tag[$];
    logic [19:0] q_addr[$];

    always #2.5 clk = ~clk;

    lrd_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_smm(req_smm), .cfg_rd_en(cfg_rd_en),
        .cfg_wr_en(cfg_wr_en), .cfg_dos_hole(cfg_dos_hole),
        .cfg_smram_en(cfg_smram_en), .rsp_valid(rsp_valid),
        .rsp_to_dram(rsp_to_dram)
    );

    // Reference model built from the requirements
    function automatic bit ref_route(input int a, input bit wr, input bit smm,
                                     input logic [12:0] re, input logic [12:0] we,
                                     input bit hole, input bit smram);
        int idx;
        if (a < 'h80000) return 1'b1;                  // R1
        if (a < 'hA0000) return !hole;                 // R2
        if (a < 'hC0000) return smm && smram;          // R3, R4
        if (a < 'hE0000) idx = (a - 'hC0000) / 'h4000; // R5
        else if (a < 'hF0000) idx = 8 + (a - 'hE0000) / 'h4000; // R6
        else idx = 12;                                 // R7
        return wr ? we[idx] : re[idx];                 // R8
    endfunction

    function automatic string ref_tag(input int a);
        if (a < 'h80000) return "R1";
        if (a < 'hA0000) return "R2";
        if (a < 'hC0000) return "R3/R4";
        if (a < 'hE0000) return "R5/R8";
        if (a < 'hF0000) return "R6/R8";
        return "R7/R8";
    endfunction

    // Boundary address list: every segment edge plus fixed-region edges
    function automatic int addr_at(input int i);
        int s;
        case (i)
            26: return 'h00000;
            27: return 'h40000;
            28: return 'h7FFFF;
            29: return 'h80000;
            30: return 'h9FFFF;
            31: return 'hA0000;
            32: return 'hBFFFF;
            default: begin
                s = i / 2;
                if (s == 12) return (i % 2 == 0) ? 'hF0000 : 'hFFFFF;
                return 'hC0000 + s * 'h4000 + ((i % 2 == 0) ? 0 : 'h3FFF);
            end
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: presents one request and pushes its expected result
    task automatic send(input int a, input bit wr, input bit smm);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 20'(a);
        req_write = wr;
        req_smm   = smm;
        q_exp.push_back(ref_route(a, wr, smm, cfg_rd_en, cfg_wr_en,
                                  cfg_dos_hole, cfg_smram_en));
        q_tag.push_back(ref_tag(a));
        q_addr.push_back(20'(a));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compares each response with the scoreboard head (R9)
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (rsp_valid) begin
                if (q_exp.size() == 0) begin
                    check(1'b0, "R9 spurious rsp_valid", 1, 0);
                end else begin
                    bit e;
                    string t;
                    logic [19:0] ad;
                    e  = q_exp.pop_front();
                    t  = q_tag.pop_front();
                    ad = q_addr.pop_front();
                    if (rsp_to_dram !== e)
                        $display("FAIL %s at addr %05h", t, ad);
                    check(rsp_to_dram === e, t, int'(rsp_to_dram), int'(e));
                end
            end else begin
                check(rsp_to_dram === 1'b0, "R9 idle target", int'(rsp_to_dram), 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Reset state, with an active request during reset (R10)
        req_valid = 1'b1;
        req_addr  = 20'h00100;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rsp_valid === 1'b0, "R10 rsp_valid", int'(rsp_valid), 0);
        check(rsp_to_dram === 1'b0, "R10 rsp_to_dram", int'(rsp_to_dram), 0);
        req_valid = 1'b0;
        rst_n  = 1'b1;
        mon_on = 1'b1;

        // Defaults: shadow segments route to PCI when all bits are clear
        send('hC0000, 1'b0, 1'b0);
        send('hFFFFF, 1'b1, 1'b0);
        idle();

        // Full boundary sweep
        for (int m = 0; m < 4; m++) begin
            cfg_dos_hole = m[0];
            cfg_smram_en = m[1];
            for (int s = 0; s < 13; s++) begin
                for (int c = 0; c < 4; c++) begin
                    @(negedge clk);
                    cfg_rd_en = c[0] ? (13'd1 << s) : 13'd0;
                    cfg_wr_en = c[1] ? (13'd1 << s) : 13'd0;
                    for (int i = 0; i < 33; i++) begin
                        for (int k = 0; k < 4; k++)
                            send(addr_at(i), k[0], k[1]);
                    end
                    idle();
                end
            end
        end

        // All segments enabled for reads only, with the hole closed again
        @(negedge clk);
        cfg_rd_en = '1;
        cfg_wr_en = '0;
        cfg_dos_hole = 1'b0;
        for (int i = 0; i < 33; i++) begin
            send(addr_at(i), 1'b0, 1'b0);
            send(addr_at(i), 1'b1, 1'b1);
        end
        idle();

        repeat (3) @(negedge clk);
        check(q_exp.size() == 0, "R9 outstanding responses", q_exp.size(), 0);
        check(rsp_valid === 1'b0, "R9 valid after idle", int'(rsp_valid), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule